// File: doc/BRIEF.md
# Programmable High/Low Cycle Clock Divider

This block divides an input clock by a ratio built from two independently programmed counts. The output spends a number of input cycles low and a number high. Each count is four bits wide, so the total ratio runs from 2 to 32. A bypass setting gives divide-by-one: the output then follows the input clock and the counters stay still.

When the duty-cycle correction is enabled and the ratio is odd, a register on the falling edge moves the output's rising edge by half an input cycle. The output is then high for exactly half of the period. A synchronous restart input reloads the channel and holds the output low. The output then starts after a programmable number of whole input cycles, so that several channels restarted together keep a known phase relation.

Settings that arrive while the channel runs are held back until a safe point. Ratio and correction changes apply at the next period boundary or at a restart. Bypass changes apply at a restart, and also at a period boundary when a running divider enters bypass. The output therefore never shows a runt pulse.

Top module: `divChannel`

## Requirements
- R1: After reset, with bypass clear, divOut stays low until the first restart (syncReq sampled high on a rising edge).
- R2: With correction disabled (dccOff=1), or with an even ratio, the output is high for highCnt+1 input cycles and then low for lowCnt+1 input cycles.
- R3: The output period equals highCnt+lowCnt+2 input cycles, and the pattern repeats without gaps.
- R4: With bypassEn=1 in effect, divOut equals the input clock level, and the phase offset has no effect.
- R5: With dccOff=0 and an odd ratio D, the output rises on the falling edge after each period start. It falls on the rising edge (D+1)/2 cycles after the period start, so it is high for D/2 input cycles.
- R6: A restart forces the output low from the edge that samples it. The first period starts on the (P+1)th rising edge after that edge, where P is phaseOfs (5 bits, 0 to 31).
- R7: Changes to lowCnt, highCnt or dccOff without a restart leave the current period unchanged. They take effect from the next period start.
- R8: Clearing bypassEn without a restart leaves the output following the input clock. Divided operation resumes only after a restart.
- R9: While syncReq is held high, divOut stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Clock being divided |
| rstN | input | 1 | Asynchronous active-low reset |
| syncReq | input | 1 | Synchronous restart, active high |
| lowCnt | input | 4 | Low phase length minus one |
| highCnt | input | 4 | High phase length minus one |
| bypassEn | input | 1 | 1 selects divide-by-one |
| dccOff | input | 1 | 1 disables duty correction on odd ratios |
| phaseOfs | input | 5 | Start delay after a restart, in input cycles |
| divOut | output | 1 | Divided clock level |

## Verification
The hardest cases to reach from the ports are settings that change while a period is in progress, and a bypass that is cleared without a restart. In both, the output must keep its old behaviour for a span that is only visible later. The bench first restarts the channel so that the cycle count is known. It then changes the settings at a chosen half-cycle sample inside the high phase, or while the channel is bypassed. Every following half-cycle is compared with a model that moves to the new settings only at the expected boundary. The half-cycle sampling also shows the half-cycle shift that the correction adds on odd ratios.

// File: rtl/divChanPkg.sv
package divChanPkg;
  localparam int CNT_W = 4;
  localparam int LEN_W = CNT_W + 2;

  typedef struct packed {
    logic [LEN_W-1:0] hiLen;
    logic [LEN_W-1:0] loLen;
    logic             idle;
  } divLenT;

  typedef struct packed {
    logic dccAct;
    logic byp;
  } divModeT;

  typedef struct packed {
    divLenT  len;
    divModeT mode;
  } divCfgT;

  typedef struct packed {
    logic clear;
    logic start;
  } divStrobeT;

  function automatic divCfgT mkCfg(input logic [CNT_W-1:0] m,
                                   input logic [CNT_W-1:0] n,
                                   input logic byp,
                                   input logic dccOff);
    divCfgT c;
    logic [LEN_W-1:0] total;
    total = LEN_W'(m) + LEN_W'(n) + LEN_W'(2);
    c.mode.byp = byp;
    c.mode.dccAct = !dccOff && total[0];
    c.len.idle = byp;
    if (c.mode.dccAct) begin
      c.len.hiLen = (total + LEN_W'(1)) >> 1;
      c.len.loLen = (total - LEN_W'(1)) >> 1;
    end else begin
      c.len.hiLen = LEN_W'(n) + LEN_W'(1);
      c.len.loLen = LEN_W'(m) + LEN_W'(1);
    end
    return c;
  endfunction
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divChanPkg::*;
#(
  parameter int OFS_W = 5
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic             syncReq,
  input  divCfgT           liveCfg,
  input  logic [OFS_W-1:0] phaseOfs,
  input  logic             wrap,
  output divStrobeT        strobe,
  output divLenT           cfgUse,
  output divModeT          modeNow
);
  divCfgT           shadowCfg;
  logic             holding;
  logic [OFS_W-1:0] waitCnt;
  logic             commitEdge;

  assign commitEdge = wrap && !shadowCfg.mode.byp;

  always_comb begin
    strobe.clear = syncReq;
    strobe.start = !syncReq && holding && (waitCnt == '0) && !shadowCfg.mode.byp;
    cfgUse = commitEdge ? liveCfg.len : shadowCfg.len;
    modeNow = shadowCfg.mode;
  end

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      shadowCfg <= '0;
      holding   <= 1'b0;
      waitCnt   <= '0;
    end else if (syncReq) begin
      shadowCfg <= liveCfg;
      holding   <= 1'b1;
      waitCnt   <= phaseOfs;
    end else if (holding) begin
      if (waitCnt == '0) holding <= 1'b0;
      else waitCnt <= waitCnt - 1'b1;
    end else if (commitEdge) begin
      shadowCfg <= liveCfg;
    end
  end

  AST_WAIT_DEC: assert property (@(posedge clkIn) disable iff (!rstN)
    (holding && waitCnt != '0 && !syncReq) |=> (waitCnt == $past(waitCnt) - 1'b1)); // R6
  AST_MODE_HELD: assert property (@(posedge clkIn) disable iff (!rstN)
    (!syncReq && !wrap) |=> (modeNow == $past(modeNow))); // R8
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divChanPkg::*;
(
  input  logic      clkIn,
  input  logic      rstN,
  input  divStrobeT strobe,
  input  divLenT    cfgUse,
  input  divModeT   modeNow,
  output logic      wrap,
  output logic      divOut
);
  logic             running;
  logic             phaseHi;
  logic             phaseHiN;
  logic [LEN_W-1:0] cnt;

  assign wrap = running && !phaseHi && (cnt == '0);

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      phaseHi <= 1'b0;
      cnt     <= '0;
    end else if (strobe.clear) begin
      running <= 1'b0;
      phaseHi <= 1'b0;
      cnt     <= '0;
    end else if (strobe.start) begin
      running <= 1'b1;
      phaseHi <= 1'b1;
      cnt     <= cfgUse.hiLen - 1'b1;
    end else if (running) begin
      if (cfgUse.idle) begin
        running <= 1'b0;
        phaseHi <= 1'b0;
        cnt     <= '0;
      end else if (cnt == '0) begin
        phaseHi <= !phaseHi;
        cnt     <= phaseHi ? cfgUse.loLen - 1'b1 : cfgUse.hiLen - 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) phaseHiN <= 1'b0;
    else       phaseHiN <= phaseHi;
  end

  always_comb begin
    if (modeNow.byp)         divOut = clkIn;
    else if (modeNow.dccAct) divOut = phaseHi && phaseHiN;
    else                     divOut = phaseHi;
  end

  AST_SYNC_LOW: assert property (@(posedge clkIn) disable iff (!rstN)
    strobe.clear |=> (!phaseHi && !running)); // R9
  AST_START_RISE: assert property (@(posedge clkIn) disable iff (!rstN)
    strobe.start |=> phaseHi); // R6
  AST_LOW_END: assert property (@(posedge clkIn) disable iff (!rstN)
    (wrap && !cfgUse.idle && !strobe.clear) |=> phaseHi); // R3
  AST_BYP_IDLE: assert property (@(posedge clkIn) disable iff (!rstN)
    modeNow.byp |-> !running); // R4
endmodule

// File: rtl/divChannel.sv
module divChannel
  import divChanPkg::*;
#(
  parameter int OFS_W = 5
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic             syncReq,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] highCnt,
  input  logic             bypassEn,
  input  logic             dccOff,
  input  logic [OFS_W-1:0] phaseOfs,
  output logic             divOut
);
  divCfgT    liveCfg;
  divStrobeT strobe;
  divLenT    cfgUse;
  divModeT   modeNow;
  logic      wrap;

  assign liveCfg = mkCfg(lowCnt, highCnt, bypassEn, dccOff);

  divCtrl #(.OFS_W(OFS_W)) u_ctrl (
    .clkIn(clkIn), .rstN(rstN), .syncReq(syncReq), .liveCfg(liveCfg),
    .phaseOfs(phaseOfs), .wrap(wrap), .strobe(strobe), .cfgUse(cfgUse),
    .modeNow(modeNow)
  );

  divDatapath u_dp (
    .clkIn(clkIn), .rstN(rstN), .strobe(strobe), .cfgUse(cfgUse),
    .modeNow(modeNow), .wrap(wrap), .divOut(divOut)
  );
endmodule

// File: tb/divChannel_bench.sv
module divChannel_bench;
  logic       clkIn = 1'b0;
  logic       rstN = 1'b0;
  logic       syncReq = 1'b0;
  logic [3:0] lowCnt = '0;
  logic [3:0] highCnt = '0;
  logic       bypassEn = 1'b0;
  logic       dccOff = 1'b0;
  logic [4:0] phaseOfs = '0;
  logic       divOut;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clkIn = ~clkIn;

  divChannel u_divChannel (
    .clkIn(clkIn), .rstN(rstN), .syncReq(syncReq), .lowCnt(lowCnt),
    .highCnt(highCnt), .bypassEn(bypassEn), .dccOff(dccOff),
    .phaseOfs(phaseOfs), .divOut(divOut)
  );

  // m, n, dccOff, ofs, expected high half-cycles per period
  localparam int NV = 9;
  localparam int VEC [NV][5] = '{
    '{0, 0, 0, 0, 2},
    '{3, 1, 1, 2, 4},
    '{2, 0, 0, 1, 2},
    '{1, 0, 0, 0, 3},
    '{1, 0, 1, 5, 2},
    '{15, 15, 0, 31, 32},
    '{0, 15, 0, 3, 17},
    '{15, 0, 1, 0, 2},
    '{4, 6, 0, 7, 14}
  };

  function automatic bit expLevel(int m, int n, int dOff, int ofs, int e, bit neg);
    int d, t, p, hi;
    bit dcc;
    d = m + n + 2;
    t = e - 1 - ofs;
    if (t < 0) return 1'b0;
    p = t % d;
    dcc = (dOff == 0) && (d % 2 == 1);
    hi = dcc ? (d + 1) / 2 : n + 1;
    if (dcc && !neg) return (p >= 1) && (p < hi);
    return p < hi;
  endfunction

  task automatic check(bit act, bit exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic doSync();
    @(negedge clkIn); syncReq = 1'b1;
    @(negedge clkIn); syncReq = 1'b0;
  endtask

  task automatic stepPos(); @(posedge clkIn); #2; endtask
  task automatic stepNeg(); @(negedge clkIn); #2; endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset and post-reset idle
    #10; check(divOut, 1'b0, "R1 in reset");
    @(negedge clkIn); rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      stepPos(); check(divOut, 1'b0, "R1 before sync");
      stepNeg(); check(divOut, 1'b0, "R1 before sync");
    end

    // Table walk: R2 R3 R5 R6
    for (int v = 0; v < NV; v++) begin
      int m, n, dOff, ofs, d, cnt;
      m = VEC[v][0]; n = VEC[v][1]; dOff = VEC[v][2]; ofs = VEC[v][3];
      d = m + n + 2; cnt = 0;
      lowCnt = 4'(m); highCnt = 4'(n); dccOff = dOff[0]; phaseOfs = 5'(ofs);
      doSync();
      for (int e = 1; e <= ofs + 2 * d + 1; e++) begin
        bit lv;
        stepPos(); lv = expLevel(m, n, dOff, ofs, e, 1'b0);
        check(divOut, lv, (e <= ofs + 1) ? "R6 offset start" : "R2/R3 waveform");
        if (e > ofs && e <= ofs + d && divOut) cnt++;
        stepNeg(); lv = expLevel(m, n, dOff, ofs, e, 1'b1);
        check(divOut, lv, (dOff == 0 && d % 2 == 1) ? "R5 corrected" : "R2 waveform");
        if (e > ofs && e <= ofs + d && divOut) cnt++;
      end
      total++;
      if (cnt != VEC[v][4]) begin
        bad++;
        $display("FAIL R5/R2 high halves vec %0d: got %0d expected %0d", v, cnt, VEC[v][4]);
      end
    end

    // R7: change mid-period, old period completes
    lowCnt = 4'd3; highCnt = 4'd3; dccOff = 1'b0; phaseOfs = '0;
    doSync();
    for (int e = 1; e <= 16; e++) begin
      bit lv;
      stepPos();
      lv = (e <= 8) ? expLevel(3, 3, 0, 0, e, 1'b0) : expLevel(1, 1, 0, 8, e, 1'b0);
      check(divOut, lv, "R7 deferred change");
      stepNeg();
      lv = (e <= 8) ? expLevel(3, 3, 0, 0, e, 1'b1) : expLevel(1, 1, 0, 8, e, 1'b1);
      check(divOut, lv, "R7 deferred change");
      if (e == 2) begin lowCnt = 4'd1; highCnt = 4'd1; end
    end

    // R4: bypass follows the clock, offset ignored
    bypassEn = 1'b1; phaseOfs = 5'd9;
    doSync();
    for (int i = 0; i < 4; i++) begin
      stepPos(); check(divOut, 1'b1, "R4 bypass high");
      stepNeg(); check(divOut, 1'b0, "R4 bypass low");
    end
    // R8: clearing bypass without sync has no effect
    bypassEn = 1'b0; lowCnt = 4'd1; highCnt = 4'd1; phaseOfs = '0;
    for (int i = 0; i < 5; i++) begin
      stepPos(); check(divOut, 1'b1, "R8 still bypassed");
      stepNeg(); check(divOut, 1'b0, "R8 still bypassed");
    end
    doSync();
    for (int e = 1; e <= 8; e++) begin
      stepPos(); check(divOut, expLevel(1, 1, 0, 0, e, 1'b0), "R8 divided after sync");
      stepNeg(); check(divOut, expLevel(1, 1, 0, 0, e, 1'b1), "R8 divided after sync");
    end

    // R9: sync held high keeps output low, then offset start
    phaseOfs = 5'd2;
    @(negedge clkIn); syncReq = 1'b1;
    for (int i = 0; i < 6; i++) begin
      stepPos(); check(divOut, 1'b0, "R9 sync held");
      stepNeg(); check(divOut, 1'b0, "R9 sync held");
    end
    syncReq = 1'b0;
    for (int e = 1; e <= 8; e++) begin
      stepPos(); check(divOut, expLevel(1, 1, 0, 2, e, 1'b0), "R6 after held sync");
      stepNeg(); check(divOut, expLevel(1, 1, 0, 2, e, 1'b1), "R6 after held sync");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule